// File: doc/BRIEF.md
# Trimmed Square-Wave Generator

This block turns a nominal 4096 Hz base tick strobe, derived upstream from a 32 kHz crystal oscillator, into a square wave on a single output. The wave can run at 1 Hz, 512 Hz or the raw base rate. A signed 8-bit trim word gives a correction in parts per million. On every base tick the trim magnitude is added to an accumulator. Each time the accumulator reaches the wrap limit, it gives back that limit and the block either adds one extra count to the corrected tick stream (positive trim) or drops one count (negative trim).

The 512 Hz and 1 Hz waves come from dividers that count the corrected stream, so they carry the correction. The base-rate wave toggles on every raw tick and ignores trim. An enable input gates the output. The internal state keeps running while the output is gated, so the wave returns with the same phase it would have had anyway.

Top module: `sqwave_trim_gen`

## Requirements
- R1: After reset the output `sq_o` is 0, and all divider phases and the ppm accumulator start from zero.
- R2: With `sel_i` equal to 2 or 3 and the enable high, `sq_o` inverts on the clock edge of every cycle in which `tick_i` is 1, whatever the trim value.
- R3: With `sel_i` equal to 1 and trim 0, `sq_o` inverts once every HALF_FAST (default 4) base ticks, giving 512 Hz at 50% duty.
- R4: With `sel_i` equal to 0 and trim 0, `sq_o` inverts once every HALF_SLOW (default 2048) base ticks, giving 1 Hz at 50% duty.
- R5: `trim_i` is two's complement. For positive trim, each tick adds the trim value to an accumulator. When the sum reaches ACC_LIMIT (default 1,000,000), ACC_LIMIT is subtracted and that tick counts as two corrected ticks in both dividers.
- R6: For negative trim, the magnitude is accumulated the same way, and a tick on which the sum reaches ACC_LIMIT counts as zero corrected ticks.
- R7: A trim of -128 (8'h80) acts exactly as -127.
- R8: While `en_i` is 0, `sq_o` is 0. The accumulator and dividers keep running, so after re-enabling, the output matches an uninterrupted run.
- R9: In a cycle without `tick_i`, no divider phase and no accumulator value changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Base tick strobe, one cycle wide, nominally 4096 per second |
| trim_i | input | 8 | Signed ppm correction (two's complement) |
| sel_i | input | 2 | Frequency select: 0 = 1 Hz, 1 = 512 Hz, 2 or 3 = base rate |
| en_i | input | 1 | Output enable |
| sq_o | output | 1 | Square-wave output |

## Verification
The assertions assume that `tick_i` is a one-cycle pulse sampled on the clock, and that `sel_i` and `en_i` stay steady around a tick when the base-rate toggle is checked. The stimulus changes inputs only on the falling clock edge and holds each mode for many ticks. It mixes tick-every-cycle and tick-every-other-cycle patterns, so idle cycles occur between ticks. Trim values of ±127, -100 and -128 are held long enough for the accumulator to wrap at least once. This puts inserted and swallowed ticks in both divider chains.

// File: rtl/sqwave_trim_gen.sv
module sqwave_trim_gen #(
  parameter int unsigned ACC_LIMIT = 1_000_000,
  parameter int unsigned HALF_FAST = 4,
  parameter int unsigned HALF_SLOW = 2048
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic [7:0] trim_i,
  input  logic [1:0] sel_i,
  input  logic       en_i,
  output logic       sq_o
);
  localparam int AW = $clog2(ACC_LIMIT + 128);
  localparam int FW = $clog2(HALF_FAST + 2);
  localparam int SW = $clog2(HALF_SLOW + 2);

  logic [AW-1:0] acc_q;
  logic [FW-1:0] c_fast_q;
  logic [SW-1:0] c_slow_q;
  logic          p_fast_q, p_slow_q, p_base_q;

  logic [7:0]    neg;
  logic [6:0]    mag;
  logic [AW-1:0] acc_sum;
  logic          wrap;
  logic [1:0]    step;
  logic [FW-1:0] f_sum;
  logic [SW-1:0] s_sum;

  assign neg     = 8'(~trim_i + 8'd1);
  assign mag     = !trim_i[7] ? trim_i[6:0] : (trim_i == 8'h80) ? 7'd127 : neg[6:0];
  assign acc_sum = acc_q + AW'(mag);
  assign wrap    = acc_sum >= AW'(ACC_LIMIT);
  assign step    = !tick_i ? 2'd0 : !wrap ? 2'd1 : trim_i[7] ? 2'd0 : 2'd2;
  assign f_sum   = c_fast_q + FW'(step);
  assign s_sum   = c_slow_q + SW'(step);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q    <= '0;
      c_fast_q <= '0;
      c_slow_q <= '0;
      p_fast_q <= 1'b0;
      p_slow_q <= 1'b0;
      p_base_q <= 1'b0;
    end else if (tick_i) begin
      acc_q    <= wrap ? acc_sum - AW'(ACC_LIMIT) : acc_sum;
      p_base_q <= ~p_base_q;
      if (f_sum >= FW'(HALF_FAST)) begin
        c_fast_q <= f_sum - FW'(HALF_FAST);
        p_fast_q <= ~p_fast_q;
      end else begin
        c_fast_q <= f_sum;
      end
      if (s_sum >= SW'(HALF_SLOW)) begin
        c_slow_q <= s_sum - SW'(HALF_SLOW);
        p_slow_q <= ~p_slow_q;
      end else begin
        c_slow_q <= s_sum;
      end
    end
  end

  assign sq_o = en_i & (sel_i[1] ? p_base_q : sel_i[0] ? p_fast_q : p_slow_q);
endmodule

// File: rtl/sqwave_trim_gen_chk.sv
module sqwave_trim_gen_chk #(
  parameter int unsigned ACC_LIMIT = 1_000_000,
  parameter int unsigned HALF_FAST = 4,
  parameter int unsigned HALF_SLOW = 2048,
  parameter int AW = 20,
  parameter int FW = 3,
  parameter int SW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick_i,
  input logic [1:0]    sel_i,
  input logic          en_i,
  input logic          sq_o,
  input logic [AW-1:0] acc_q,
  input logic [FW-1:0] c_fast_q,
  input logic [SW-1:0] c_slow_q,
  input logic          p_fast_q,
  input logic          p_slow_q
);
  // R8
  gate_low_chk: assert property (@(posedge clk) disable iff (!rst_n) !en_i |-> !sq_o);

  // R2
  base_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i[1] && en_i && $past(sel_i[1] && en_i && tick_i)) |-> sq_o != $past(sq_o));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> ($stable(acc_q) && $stable(p_fast_q) && $stable(p_slow_q)));

  // R5
  acc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) acc_q < AW'(ACC_LIMIT));

  // R3
  fast_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) c_fast_q < FW'(HALF_FAST));

  // R4
  slow_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) c_slow_q < SW'(HALF_SLOW));
endmodule

bind sqwave_trim_gen sqwave_trim_gen_chk #(
  .ACC_LIMIT(ACC_LIMIT), .HALF_FAST(HALF_FAST), .HALF_SLOW(HALF_SLOW),
  .AW(AW), .FW(FW), .SW(SW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .sel_i(sel_i), .en_i(en_i), .sq_o(sq_o),
  .acc_q(acc_q), .c_fast_q(c_fast_q), .c_slow_q(c_slow_q),
  .p_fast_q(p_fast_q), .p_slow_q(p_slow_q)
);

// File: tb/sqwave_trim_gen_tb.sv
module sqwave_trim_gen_tb;
  localparam int LIMIT = 1_000_000;
  localparam int HF = 4;
  localparam int HS = 2048;

  typedef struct { logic val; string tag; } exp_t;

  logic clk = 1'b0, rst_n = 1'b0, tick_i = 1'b0, en_i = 1'b0;
  logic [7:0] trim_i = 8'd0;
  logic [1:0] sel_i = 2'd0;
  logic sq_o;

  int total = 0, bad = 0;
  bit finished = 0;
  exp_t q[$];

  int m_acc = 0, m_cf = 0, m_cs = 0;
  bit m_pf = 0, m_ps = 0, m_pb = 0;

  always #4 clk = ~clk;

  sqwave_trim_gen u_dut (.clk(clk), .rst_n(rst_n), .tick_i(tick_i), .trim_i(trim_i),
                         .sel_i(sel_i), .en_i(en_i), .sq_o(sq_o));

  task automatic check(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: sq_o=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive(input bit tk, input int trim, input int sel, input bit en, input string tag);
    int mag, cnt;
    exp_t e;
    @(negedge clk);
    tick_i = tk; trim_i = 8'(trim); sel_i = 2'(sel); en_i = en;
    if (tk) begin
      mag = (trim < 0) ? ((trim < -127) ? 127 : -trim) : trim;
      m_acc += mag;
      cnt = 1;
      if (m_acc >= LIMIT) begin
        m_acc -= LIMIT;
        cnt = (trim < 0) ? 0 : 2;
      end
      m_pb = ~m_pb;
      m_cf += cnt;
      if (m_cf >= HF) begin m_cf -= HF; m_pf = ~m_pf; end
      m_cs += cnt;
      if (m_cs >= HS) begin m_cs -= HS; m_ps = ~m_ps; end
    end
    e.val = en & ((sel >= 2) ? m_pb : (sel == 1) ? m_pf : m_ps);
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic run(input int n, input int gap, input int trim, input int sel, input bit en, input string tag);
    for (int i = 0; i < n; i++) drive((i % gap) == 0, trim, sel, en, tag);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        check(sq_o, e.val, e.tag);
      end
    end
  end

  initial begin : watchdog
    #(8 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    en_i = 1'b1;
    #1;
    check(sq_o, 1'b0, "R1 reset");
    // R2: base rate, uncorrected, two tick patterns
    run(20, 1, 50, 2, 1, "R2 sel2");
    run(20, 2, -90, 3, 1, "R2 sel3");
    // R3 / R4 with zero trim (accumulator holds its value)
    run(40, 2, 0, 1, 1, "R3 fast");
    run(5000, 1, 0, 0, 1, "R4 slow");
    // R5 positive trim inserts ticks
    run(16000, 1, 127, 1, 1, "R5 fast");
    run(9000, 1, 127, 0, 1, "R5 slow");
    // R6 negative trim swallows ticks
    run(12000, 1, -100, 1, 1, "R6 fast");
    run(8000, 2, -100, 0, 1, "R6 slow");
    // R7 clamp of -128
    run(16000, 1, -128, 1, 1, "R7 clamp");
    // R8 gating keeps phase
    run(300, 1, 5, 1, 0, "R8 gated");
    run(40, 1, 5, 1, 1, "R8 resumed");
    run(3000, 1, 5, 0, 0, "R8 gated slow");
    run(40, 1, 5, 0, 1, "R8 resumed slow");
    // R9 idle cycles hold the output
    run(60, 3, 127, 1, 1, "R9 idle");
    repeat (3) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule